// File: doc/BRIEF.md
# Latency-Insensitive Relay Chain

This block is a chain of pipeline stages placed on a long point-to-point channel so that each wire segment fits within one clock period. Each packet is a payload plus one void bit. A void bit of 0 marks a true packet. A void bit of 1 marks an empty slot that carries nothing. Backpressure runs the other way on a stop line. The sender must not treat a packet as delivered while the stop it sees is high. The receiver raises its stop when it cannot take the packet now on offer.

Each stage has a main slot, which drives its output, and an auxiliary slot. Because every stop signal leaves a stage through a register, a sender learns about a stall one cycle late. The auxiliary slot catches the one true packet that arrives during that cycle, so nothing is lost. When the stall ends, the stage sends its main slot first and its auxiliary slot on the next cycle. The number of stages is a parameter. A count of zero gives a plain wire.

Top module: `lirs_chain`

## Requirements
- R1: A packet with the void bit at 1 is never delivered as a true packet. If only void packets are offered, `out_void` stays 1.
- R2: While reset is held, and after it is released, every slot is void, `out_void` is 1 and `stop_out` is 0.
- R3: If the output is never stalled, a true packet accepted at a clock edge appears on `out_data` with `out_void` = 0 exactly STAGES clock edges later.
- R4: In a cycle where `stop_in` is 1, the following cycle shows the same `out_void` and `out_data`.
- R5: `stop_out` comes straight from a register. It rises only in the cycle after a true packet was offered on the input while `stop_out` was 0.
- R6: A void input offered during a stall is never stored, so it never raises `stop_out`.
- R7: After `stop_in` falls on a fully stalled chain, `stop_out` stays 1 for STAGES-1 more cycles and is 0 in the STAGES-th cycle. Held packets leave in the order they arrived.
- R8: Under any pattern of `stop_in` and offers, the true packets delivered (`out_void` = 0 while `stop_in` = 0) match the true packets accepted (`in_void` = 0 while `stop_out` = 0), in the same order, with none lost and none repeated.
- R9: If a back-to-back stream is flowing and `stop_in` is then held at 1, the chain absorbs exactly 2*STAGES true packets before `stop_out` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_data | input | DATA_W | Payload offered by the upstream sender |
| in_void | input | 1 | 1 = the offered slot is empty |
| stop_out | output | 1 | Stop sent back to the upstream sender (registered) |
| out_data | output | DATA_W | Payload presented downstream |
| out_void | output | 1 | 1 = the presented slot is empty |
| stop_in | input | 1 | Stop from the downstream receiver |

## Verification
The hardest case to reach is a chain where every auxiliary slot is full. Reaching it takes two things in a particular order: a back-to-back stream must already fill every main slot, and only then is `stop_in` raised and held. The bench keeps offering packets until `stop_out` settles high, then counts the packets held and releases the stall. It checks the cycle in which `stop_out` falls and the order in which the packets drain. A long run with pseudo-random stop and offer patterns then checks the delivered sequence against a queue of the accepted packets.

// File: rtl/lirs_pkg.sv
package lirs_pkg;

   // Per-cycle decision of one relay stage
   typedef enum logic [1:0] {
      ACT_PASS    = 2'd0,  // output free, no spare held: main takes input
      ACT_PROMOTE = 2'd1,  // output free, spare held: main takes spare
      ACT_HOLD    = 2'd2,  // output stalled, nothing captured
      ACT_CAPTURE = 2'd3   // output stalled, true input goes to spare
   } stage_act_e;

   function automatic stage_act_e pick_act(input logic stall,
                                           input logic spare_full,
                                           input logic in_is_void);
      if (!stall)
         return spare_full ? ACT_PROMOTE : ACT_PASS;
      else if (!spare_full && !in_is_void)
         return ACT_CAPTURE;
      else
         return ACT_HOLD;
   endfunction

endpackage

// File: rtl/lirs_slot.sv
module lirs_slot #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              d_void,
   input  logic [DATA_W-1:0] d_data,
   output logic              q_void,
   output logic [DATA_W-1:0] q_data
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_void <= 1'b1;
         q_data <= '0;
      end else if (load) begin
         q_void <= d_void;
         q_data <= d_data;
      end
   end

endmodule

// File: rtl/lirs_stage.sv
module lirs_stage
   import lirs_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              up_void,
   input  logic [DATA_W-1:0] up_data,
   output logic              up_stop,
   output logic              dn_void,
   output logic [DATA_W-1:0] dn_data,
   input  logic              dn_stop
);

   logic              main_void, spare_void;
   logic [DATA_W-1:0] main_data, spare_data;
   logic              main_ld, spare_ld;
   logic              main_d_void, spare_d_void;
   logic [DATA_W-1:0] main_d_data, spare_d_data;
   logic              spare_full;
   stage_act_e        act;

   assign spare_full = ~spare_void;

   always_comb begin
      act          = pick_act(dn_stop, spare_full, up_void);
      main_ld      = 1'b0;
      main_d_void  = up_void;
      main_d_data  = up_data;
      spare_ld     = 1'b0;
      spare_d_void = up_void;
      spare_d_data = up_data;
      unique case (act)
         ACT_PASS: begin
            main_ld = 1'b1;
         end
         ACT_PROMOTE: begin
            main_ld      = 1'b1;
            main_d_void  = spare_void;
            main_d_data  = spare_data;
            spare_ld     = 1'b1;
            spare_d_void = 1'b1;
            spare_d_data = spare_data;
         end
         ACT_CAPTURE: begin
            spare_ld = 1'b1;
         end
         default: begin
         end
      endcase
   end

   lirs_slot #(.DATA_W(DATA_W)) u_main (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (main_ld),
      .d_void (main_d_void),
      .d_data (main_d_data),
      .q_void (main_void),
      .q_data (main_data)
   );

   lirs_slot #(.DATA_W(DATA_W)) u_spare (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (spare_ld),
      .d_void (spare_d_void),
      .d_data (spare_d_data),
      .q_void (spare_void),
      .q_data (spare_data)
   );

   // stop is the spare slot's occupancy flop: registered by construction
   assign up_stop = spare_full;
   assign dn_void = main_void;
   assign dn_data = main_data;

endmodule

// File: rtl/lirs_chain.sv
module lirs_chain #(
   parameter int DATA_W = 16,
   parameter int STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] in_data,
   input  logic              in_void,
   output logic              stop_out,
   output logic [DATA_W-1:0] out_data,
   output logic              out_void,
   input  logic              stop_in
);

   localparam int NODES = STAGES + 1;

   if (DATA_W < 1) begin : g_bad_width
      $error("lirs_chain: DATA_W must be at least 1");
   end
   if (STAGES < 0 || STAGES > 64) begin : g_bad_depth
      $error("lirs_chain: STAGES must lie in 0..64");
   end

   if (STAGES == 0) begin : g_wire
      assign out_data = in_data;
      assign out_void = in_void;
      assign stop_out = stop_in;
   end else begin : g_pipe
      logic              n_void [NODES];
      logic [DATA_W-1:0] n_data [NODES];
      logic              n_stop [NODES];

      assign n_void[0]      = in_void;
      assign n_data[0]      = in_data;
      assign n_stop[STAGES] = stop_in;

      for (genvar k = 0; k < STAGES; k++) begin : g_stage
         lirs_stage #(.DATA_W(DATA_W)) u_stage (
            .clk     (clk),
            .rst_n   (rst_n),
            .up_void (n_void[k]),
            .up_data (n_data[k]),
            .up_stop (n_stop[k]),
            .dn_void (n_void[k+1]),
            .dn_data (n_data[k+1]),
            .dn_stop (n_stop[k+1])
         );
      end

      assign out_void = n_void[STAGES];
      assign out_data = n_data[STAGES];
      assign stop_out = n_stop[0];
   end

endmodule

// File: rtl/lirs_chain_chk.sv
module lirs_chain_chk #(
   parameter int DATA_W = 16,
   parameter int STAGES = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic [DATA_W-1:0] in_data,
   input logic              in_void,
   input logic              stop_out,
   input logic [DATA_W-1:0] out_data,
   input logic              out_void,
   input logic              stop_in
);

   logic [15:0] held;
   logic        took, gave;

   assign took = ~in_void & ~stop_out;
   assign gave = ~out_void & ~stop_in;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) held <= '0;
      else        held <= held + 16'(took) - 16'(gave);
   end

   if (STAGES > 0) begin : g_props
      a_r2_reset_void: assert property (@(posedge clk)
         !rst_n |=> (out_void && !stop_out));

      a_r4_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
         stop_in |=> ($stable(out_void) && $stable(out_data)));

      a_r5_stop_needs_true_in: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(stop_out) |-> $past(!in_void));

      a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
         held <= 16'(2 * STAGES));

      a_r8_no_phantom: assert property (@(posedge clk) disable iff (!rst_n)
         gave |-> (held != 16'd0));
   end

endmodule

bind lirs_chain lirs_chain_chk #(.DATA_W(DATA_W), .STAGES(STAGES)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_data  (in_data),
   .in_void  (in_void),
   .stop_out (stop_out),
   .out_data (out_data),
   .out_void (out_void),
   .stop_in  (stop_in)
);

// File: tb/lirs_chain_tb.sv
`timescale 1ns/1ps
module lirs_chain_tb;

   localparam int W  = 16;
   localparam int NS = 2;
   localparam int NPAT = 32;
   // each entry: {offer, stop}
   localparam logic [1:0] PAT [NPAT] = '{
      2'b10, 2'b10, 2'b10, 2'b11, 2'b11, 2'b10, 2'b10, 2'b00,
      2'b11, 2'b01, 2'b10, 2'b11, 2'b10, 2'b11, 2'b10, 2'b00,
      2'b10, 2'b10, 2'b11, 2'b11, 2'b11, 2'b11, 2'b00, 2'b00,
      2'b10, 2'b01, 2'b10, 2'b01, 2'b10, 2'b00, 2'b00, 2'b00
   };

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] in_data = '0;
   logic         in_void = 1'b1;
   logic         stop_out;
   logic [W-1:0] out_data;
   logic         out_void;
   logic         stop_in = 1'b0;

   int n_cmp = 0;
   int n_bad = 0;

   logic [W-1:0] sb_q [$];
   bit           pend = 1'b0;
   logic [W-1:0] pend_data = '0;
   logic [W-1:0] next_val = 16'h0100;

   always #10 clk = ~clk;

   lirs_chain #(.DATA_W(W), .STAGES(NS)) u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_data  (in_data),
      .in_void  (in_void),
      .stop_out (stop_out),
      .out_data (out_data),
      .out_void (out_void),
      .stop_in  (stop_in)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // one clock cycle: drive after falling edge, sample before rising edge
   task automatic step(input bit offer, input bit stp);
      @(negedge clk);
      if (!pend && offer) begin
         pend      = 1'b1;
         pend_data = next_val;
         next_val  = next_val + 16'h0001;
      end
      in_void = !pend;
      in_data = pend ? pend_data : 16'hBEEF;
      stop_in = stp;
      #2;
      if (!out_void && !stop_in) begin
         if (sb_q.size() == 0)
            chk(1'b0, "R8 delivery with nothing accepted", 32'(out_data), 32'hFFFF_FFFF);
         else begin
            chk(out_data == sb_q[0], "R8 delivered order", 32'(out_data), 32'(sb_q[0]));
            void'(sb_q.pop_front());
         end
      end
      if (pend && !stop_out) begin
         sb_q.push_back(pend_data);
         pend = 1'b0;
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n   = 1'b0;
      in_void = 1'b1;
      stop_in = 1'b0;
      pend    = 1'b0;
      sb_q.delete();
      repeat (2) @(negedge clk);
      chk(out_void == 1'b1, "R2 out_void in reset", 32'(out_void), 32'd1);
      chk(stop_out == 1'b0, "R2 stop_out in reset", 32'(stop_out), 32'd0);
      rst_n = 1'b1;
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      #(200000 * 20);
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
   end

   initial begin
      logic [W-1:0] held_val;
      logic [15:0]  lfsr;

      do_reset();
      step(1'b0, 1'b0);
      chk(out_void == 1'b1, "R2 out_void after reset", 32'(out_void), 32'd1);
      chk(stop_out == 1'b0, "R2 stop_out after reset", 32'(stop_out), 32'd0);

      // table walk, scoreboard checks R8
      for (int i = 0; i < NPAT; i++) step(PAT[i][1], PAT[i][0]);
      for (int i = 0; i < 12; i++) step(1'b0, 1'b0);
      chk(sb_q.size() == 0, "R8 table drained", 32'(sb_q.size()), 32'd0);

      // R1 / R6: voids during a stall are not stored
      do_reset();
      for (int i = 0; i < 6; i++) begin
         step(1'b0, 1'b1);
         chk(stop_out == 1'b0, "R6 void not stored", 32'(stop_out), 32'd0);
      end
      for (int i = 0; i < 4; i++) begin
         step(1'b0, 1'b0);
         chk(out_void == 1'b1, "R1 void never delivered", 32'(out_void), 32'd1);
      end

      // R3: latency of STAGES edges
      step(1'b1, 1'b0);
      step(1'b0, 1'b0);
      chk(out_void == 1'b1, "R3 not yet at output", 32'(out_void), 32'd1);
      step(1'b0, 1'b0);
      chk(out_void == 1'b0, "R3 at output after STAGES edges", 32'(out_void), 32'd0);
      for (int i = 0; i < 4; i++) step(1'b0, 1'b0);

      // R9 / R4 / R7: stall a full stream
      for (int i = 0; i < 10; i++) step(1'b1, 1'b0);
      step(1'b1, 1'b1);
      held_val = out_data;
      for (int i = 0; i < 3; i++) begin
         step(1'b1, 1'b1);
         chk(out_data == held_val && out_void == 1'b0, "R4 output held in stall",
             32'(out_data), 32'(held_val));
      end
      chk(stop_out == 1'b1, "R9 stop_out high when full", 32'(stop_out), 32'd1);
      chk(sb_q.size() == 2 * NS, "R9 packets absorbed", 32'(sb_q.size()), 32'(2 * NS));
      step(1'b1, 1'b0);
      chk(stop_out == 1'b1, "R7 stop_out on release", 32'(stop_out), 32'd1);
      step(1'b1, 1'b0);
      chk(stop_out == 1'b1, "R7 stop_out one cycle later", 32'(stop_out), 32'd1);
      step(1'b1, 1'b0);
      chk(stop_out == 1'b0, "R7 stop_out cleared", 32'(stop_out), 32'd0);
      for (int i = 0; i < 12; i++) step(1'b0, 1'b0);
      chk(sb_q.size() == 0, "R7 drained in order", 32'(sb_q.size()), 32'd0);

      // R8: pseudo-random stop and offer
      lfsr = 16'hACE1;
      for (int i = 0; i < 3000; i++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         step(lfsr[0] | lfsr[3], lfsr[5] & (lfsr[7] | lfsr[2]));
      end
      for (int i = 0; i < 20; i++) step(1'b0, 1'b0);
      chk(sb_q.size() == 0, "R8 random run drained", 32'(sb_q.size()), 32'd0);
      chk(pend == 1'b0, "R8 last offer accepted", 32'(pend), 32'd0);

      finish_run();
   end

endmodule